// File: doc/BRIEF.md
# Dual-Strobe BCD Up/Down Counter

This block is a four-bit counter that steps through 0 to 9 (or 0 to 15 when built in binary mode). It has no direction input. Instead, two count strobes, one for counting up and one for counting down, arrive as ordinary signals. A system clock samples them and acts on their rising edges. A level-sensitive parallel load copies a preset value into the counter. An active-high clear forces the count to zero and wins over every other input.

Two active-low terminal outputs allow stages to be chained. The carry output falls while the count sits at its top value and the up strobe is low. The borrow output falls while the count is zero and the down strobe is low. Each output rises again with the strobe edge that causes the wrap. A higher stage therefore counts when it sees the lower stage's carry on its up strobe, or the lower stage's borrow on its down strobe.

A decade build that holds a code from 10 to 15, which only a load can put there, returns to the legal sequence on its next count.

Top module: `updn_decade_counter`

## Requirements
- R1: A rising edge on `up_stb`, while `dn_stb` is high, adds one to `count_q`. The top value wraps to 0.
- R2: A rising edge on `dn_stb`, while `up_stb` is high, subtracts one from `count_q`. Zero wraps to the top value.
- R3: No count occurs in two cases: a strobe rises while the other strobe is low, or both strobes rise in the same sampled cycle.
- R4: While `load_n` is low, `count_q` takes `preset_val` at each clock edge, and strobe edges have no effect.
- R5: While `master_clr` is high, `count_q` is 0 without waiting for a clock edge, even when `load_n` is low.
- R6: `carry_n` is 0 exactly when `count_q` equals the top value and the synchronized `up_stb` is low.
- R7: `borrow_n` is 0 exactly when `count_q` is 0 and the synchronized `dn_stb` is low.
- R8: In decade mode, from a code from 10 to 15, an up count gives 0 and a down count gives 9.
- R9: With `BINARY_MODE`=1 the top value is 15: an up count from 15 gives 0, and a down count from 0 gives 15.
- R10: With `SYNC_DEPTH`=2, `count_q` changes at the third rising clock edge after a strobe rises, and is unchanged after the second.
- R11: When a second counter takes the first counter's `carry_n` as its up strobe and `borrow_n` as its down strobe, the pair counts as a two-digit decimal value, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| master_clr | input | 1 | Active-high asynchronous clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| preset_val | input | 4 | Value copied into the counter during a load |
| up_stb | input | 1 | Up count strobe, acts on its rising edge |
| dn_stb | input | 1 | Down count strobe, acts on its rising edge |
| count_q | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count going up |
| borrow_n | output | 1 | Active-low terminal count going down |

## Verification
The assertions assume three things about the inputs:
- Each strobe is held steady for longer than the synchronizer depth in clock cycles.
- The clear is released only while both strobes are high, so that no edge is seen when the clear lets go.
- `load_n` changes only between clock edges.

The stimulus drives every input on the falling clock edge. It holds each strobe level for four cycles, which keeps every edge cleanly separated. It also returns both strobes high before any clear or load is released. Under these conditions the terminal outputs and the count can be predicted cycle by cycle from the strobe history alone.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
   localparam int CNT_W = 4;
   typedef logic [CNT_W-1:0] cnt_t;

   function automatic cnt_t step_up(input cnt_t v, input cnt_t top);
      return (v >= top) ? cnt_t'(0) : cnt_t'(v + 1'b1);
   endfunction

   function automatic cnt_t step_dn(input cnt_t v, input cnt_t top);
      return ((v == 0) || (v > top)) ? top : cnt_t'(v - 1'b1);
   endfunction
endpackage

// File: rtl/updn_stb_sync.sv
module updn_stb_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic stb_in,
   output logic stb_lvl,
   output logic stb_rise
);
   localparam int LAST = DEPTH;

   logic [LAST:0] shf;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("updn_stb_sync: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr) shf <= '1;
      else     shf <= {shf[LAST-1:0], stb_in};
   end

   assign stb_lvl  = shf[LAST-1];
   assign stb_rise = shf[LAST-1] & ~shf[LAST];
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
   import updn_cnt_pkg::*;
#(
   parameter bit BINARY = 1'b0
) (
   input  logic clk,
   input  logic clr,
   input  logic load_n,
   input  cnt_t preset,
   input  logic up_rise,
   input  logic dn_rise,
   input  logic up_lvl,
   input  logic dn_lvl,
   output cnt_t cnt
);
   localparam cnt_t TOP = BINARY ? cnt_t'(15) : cnt_t'(9);

   logic up_go, dn_go;
   cnt_t nxt_up, nxt_dn;

   assign up_go = up_rise & dn_lvl & ~dn_rise;
   assign dn_go = dn_rise & up_lvl & ~up_rise;

   generate
      if (BINARY) begin : g_bin
         assign nxt_up = cnt_t'(cnt + 1'b1);
         assign nxt_dn = cnt_t'(cnt - 1'b1);
      end else begin : g_dec
         assign nxt_up = step_up(cnt, TOP);
         assign nxt_dn = step_dn(cnt, TOP);
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr)         cnt <= '0;
      else if (!load_n) cnt <= preset;
      else if (up_go)  cnt <= nxt_up;
      else if (dn_go)  cnt <= nxt_dn;
   end

   // R4
   load_chk: assert property (@(posedge clk) disable iff (clr)
      !load_n |=> (cnt == $past(preset)));

   // R3
   idle_chk: assert property (@(posedge clk) disable iff (clr)
      (load_n && !up_rise && !dn_rise) |=> $stable(cnt));

   // R3
   both_rise_chk: assert property (@(posedge clk) disable iff (clr)
      (load_n && up_rise && dn_rise) |=> $stable(cnt));

   // R5
   clr_chk: assert property (@(posedge clk) clr |-> (cnt == '0));

   generate
      if (!BINARY) begin : g_dec_chk
         // R8
         bad_code_up_chk: assert property (@(posedge clk) disable iff (clr)
            (load_n && cnt > TOP && up_rise && dn_lvl && !dn_rise) |=> (cnt == '0));
         // R8
         bad_code_dn_chk: assert property (@(posedge clk) disable iff (clr)
            (load_n && cnt > TOP && dn_rise && up_lvl && !up_rise) |=> (cnt == TOP));
      end
   endgenerate
endmodule

// File: rtl/updn_tc_decode.sv
module updn_tc_decode
   import updn_cnt_pkg::*;
#(
   parameter bit BINARY = 1'b0
) (
   input  cnt_t cnt,
   input  logic up_lvl,
   input  logic dn_lvl,
   output logic carry_n,
   output logic borrow_n
);
   localparam cnt_t TOP = BINARY ? cnt_t'(15) : cnt_t'(9);

   assign carry_n  = ~((cnt == TOP) & ~up_lvl);
   assign borrow_n = ~((cnt == '0) & ~dn_lvl);
endmodule

// File: rtl/updn_decade_counter.sv
module updn_decade_counter
   import updn_cnt_pkg::*;
#(
   parameter bit BINARY_MODE = 1'b0,
   parameter int SYNC_DEPTH  = 2
) (
   input  logic       clk,
   input  logic       master_clr,
   input  logic       load_n,
   input  logic [3:0] preset_val,
   input  logic       up_stb,
   input  logic       dn_stb,
   output logic [3:0] count_q,
   output logic       carry_n,
   output logic       borrow_n
);
   localparam cnt_t TOP = BINARY_MODE ? cnt_t'(15) : cnt_t'(9);

   generate
      if (SYNC_DEPTH < 2 || SYNC_DEPTH > 4) begin : g_bad_cfg
         $error("updn_decade_counter: SYNC_DEPTH must be 2 to 4");
      end
   endgenerate

   logic up_lvl, up_rise, dn_lvl, dn_rise;
   cnt_t cnt;

   updn_stb_sync #(.DEPTH(SYNC_DEPTH)) u_up_sync (
      .clk(clk), .clr(master_clr), .stb_in(up_stb),
      .stb_lvl(up_lvl), .stb_rise(up_rise));

   updn_stb_sync #(.DEPTH(SYNC_DEPTH)) u_dn_sync (
      .clk(clk), .clr(master_clr), .stb_in(dn_stb),
      .stb_lvl(dn_lvl), .stb_rise(dn_rise));

   updn_count_core #(.BINARY(BINARY_MODE)) u_core (
      .clk(clk), .clr(master_clr), .load_n(load_n), .preset(preset_val),
      .up_rise(up_rise), .dn_rise(dn_rise), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
      .cnt(cnt));

   updn_tc_decode #(.BINARY(BINARY_MODE)) u_tc (
      .cnt(cnt), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
      .carry_n(carry_n), .borrow_n(borrow_n));

   assign count_q = cnt;

   // R6
   carry_lo_chk: assert property (@(posedge clk) disable iff (master_clr)
      !carry_n |-> (count_q == TOP));

   // R7
   borrow_lo_chk: assert property (@(posedge clk) disable iff (master_clr)
      !borrow_n |-> (count_q == '0));
endmodule

// File: tb/tb_updn_decade_counter.sv
module tb_updn_decade_counter;
   logic clk = 1'b0;
   logic master_clr, load_n, up_stb, dn_stb;
   logic [3:0] preset_val;
   logic [3:0] cnt_dec, cnt_bin, cnt_hi;
   logic carry_dec, borrow_dec, carry_bin, borrow_bin, carry_hi, borrow_hi;

   int checks = 0;
   int errors = 0;
   int m_dec, m_bin;
   bit finished = 1'b0;

   always #2.5ns clk = ~clk;

   updn_decade_counter #(.BINARY_MODE(1'b0), .SYNC_DEPTH(2)) dut (
      .clk(clk), .master_clr(master_clr), .load_n(load_n), .preset_val(preset_val),
      .up_stb(up_stb), .dn_stb(dn_stb), .count_q(cnt_dec),
      .carry_n(carry_dec), .borrow_n(borrow_dec));

   updn_decade_counter #(.BINARY_MODE(1'b1), .SYNC_DEPTH(2)) dut_bin (
      .clk(clk), .master_clr(master_clr), .load_n(load_n), .preset_val(preset_val),
      .up_stb(up_stb), .dn_stb(dn_stb), .count_q(cnt_bin),
      .carry_n(carry_bin), .borrow_n(borrow_bin));

   updn_decade_counter #(.BINARY_MODE(1'b0), .SYNC_DEPTH(2)) dut_hi (
      .clk(clk), .master_clr(master_clr), .load_n(1'b1), .preset_val(4'd0),
      .up_stb(carry_dec), .dn_stb(borrow_dec), .count_q(cnt_hi),
      .carry_n(carry_hi), .borrow_n(borrow_hi));

   function automatic int nxt_up(int v, int top);
      return (v >= top) ? 0 : v + 1;
   endfunction
   function automatic int nxt_dn(int v, int top);
      return (v == 0 || v > top) ? top : v - 1;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_up(string req);
      up_stb = 1'b0;
      tick(4);
      check({req, " carry_n (R6)"}, carry_dec, (m_dec == 9) ? 0 : 1);
      check({req, " bin carry_n (R6)"}, carry_bin, (m_bin == 15) ? 0 : 1);
      up_stb = 1'b1;
      tick(4);
      m_dec = nxt_up(m_dec, 9);
      m_bin = nxt_up(m_bin, 15);
      check({req, " count"}, cnt_dec, m_dec);
      check({req, " bin count (R9)"}, cnt_bin, m_bin);
      check({req, " carry_n high after edge (R6)"}, carry_dec, 1);
   endtask

   task automatic pulse_dn(string req);
      dn_stb = 1'b0;
      tick(4);
      check({req, " borrow_n (R7)"}, borrow_dec, (m_dec == 0) ? 0 : 1);
      check({req, " bin borrow_n (R7)"}, borrow_bin, (m_bin == 0) ? 0 : 1);
      dn_stb = 1'b1;
      tick(4);
      m_dec = nxt_dn(m_dec, 9);
      m_bin = nxt_dn(m_bin, 15);
      check({req, " count"}, cnt_dec, m_dec);
      check({req, " bin count (R9)"}, cnt_bin, m_bin);
      check({req, " borrow_n high after edge (R7)"}, borrow_dec, 1);
   endtask

   task automatic do_clear();
      master_clr = 1'b1;
      tick(2);
      master_clr = 1'b0;
      tick(2);
      m_dec = 0;
      m_bin = 0;
   endtask

   task automatic do_load(int v);
      preset_val = 4'(v);
      load_n = 1'b0;
      tick(2);
      load_n = 1'b1;
      tick(1);
      m_dec = v;
      m_bin = v;
   endtask

   initial begin
      #1ms;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      master_clr = 1'b1;
      load_n = 1'b1;
      up_stb = 1'b1;
      dn_stb = 1'b1;
      preset_val = 4'd0;
      m_dec = 0;
      m_bin = 0;
      tick(3);
      check("R5 reset count", cnt_dec, 0);
      check("R7 reset borrow_n", borrow_dec, 1);
      check("R6 reset carry_n", carry_dec, 1);
      master_clr = 1'b0;
      tick(2);

      // R1 and R9: sweep upward through two wraps
      for (int i = 0; i < 22; i++) pulse_up("R1 up sweep");
      // R2 and R9: sweep downward through two wraps
      for (int i = 0; i < 22; i++) pulse_dn("R2 down sweep");

      // R10: latency of the count change
      do_clear();
      up_stb = 1'b0;
      tick(4);
      up_stb = 1'b1;
      tick(2);
      check("R10 no change after second edge", cnt_dec, 0);
      tick(1);
      check("R10 change at third edge", cnt_dec, 1);
      tick(3);

      // R3: one strobe rises while the other is low
      do_clear();
      up_stb = 1'b0;
      dn_stb = 1'b0;
      tick(4);
      up_stb = 1'b1;
      tick(4);
      check("R3 up rise while down low", cnt_dec, 0);
      dn_stb = 1'b1;
      tick(4);
      check("R3 down rise while up high counts", cnt_dec, 9);
      m_dec = 9;
      m_bin = 15;
      up_stb = 1'b0;
      dn_stb = 1'b0;
      tick(4);
      up_stb = 1'b1;
      dn_stb = 1'b1;
      tick(4);
      check("R3 both rise together", cnt_dec, 9);
      check("R3 both rise together bin", cnt_bin, 15);

      // R4 and R8: load every code, then count both ways
      for (int p = 0; p < 16; p++) begin
         do_load(p);
         check("R4 load value", cnt_dec, p);
         pulse_up("R8 up from loaded code");
         do_load(p);
         pulse_dn("R8 down from loaded code");
      end

      // R4: strobe edges ignored while loading
      preset_val = 4'd3;
      load_n = 1'b0;
      tick(2);
      up_stb = 1'b0;
      tick(4);
      up_stb = 1'b1;
      tick(4);
      dn_stb = 1'b0;
      tick(4);
      dn_stb = 1'b1;
      tick(4);
      check("R4 strobes ignored during load", cnt_dec, 3);

      // R5: clear overrides load, without a clock edge
      preset_val = 4'd7;
      @(posedge clk);
      #1ns;
      master_clr = 1'b1;
      #0.5ns;
      check("R5 async clear", cnt_dec, 0);
      tick(2);
      check("R5 clear over load", cnt_dec, 0);
      load_n = 1'b1;
      tick(1);
      master_clr = 1'b0;
      tick(2);
      check("R5 stays zero after release", cnt_dec, 0);

      // R11: two-stage chain
      do_clear();
      for (int i = 0; i < 25; i++) pulse_up("R11 chain up");
      tick(6);
      check("R11 chain up low digit", cnt_dec, 5);
      check("R11 chain up high digit", cnt_hi, 2);
      for (int i = 0; i < 26; i++) pulse_dn("R11 chain down");
      tick(6);
      check("R11 chain down low digit", cnt_dec, 9);
      check("R11 chain down high digit", cnt_hi, 9);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule